// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits on the read path of a flash device model. While an internal program or erase operation runs, it changes two bits of every byte returned to the host. The host can then poll for completion without knowing how long the operation takes. The block accepts a start command that says which kind of operation begins and gives the top bit of the last byte loaded. It runs a busy interval of a parameterised number of clock cycles, which differs for program and for erase. On each read it returns the array byte with status bits substituted.

Two status methods are offered, and a host may use either:
- **Data polling (bit 7).** During a program operation, bit 7 reads as the inverse of the loaded byte's top bit. During an erase operation, bit 7 reads as 0. Once the operation is done, bit 7 shows the real stored value again.
- **Toggle bit (bit 6).** Bit 6 flips on every successive read while the operation is busy. It stops flipping when the operation ends.

Bits 5 to 0 always pass through unchanged. The returned byte is registered and is updated only when a read strobe rises.

Top module: `pe_status_reporter`

## Requirements
- R1: A command seen while idle (`cmd_valid`=1, `cmd_erase`=0 for program, 1 for erase) raises `busy` on the next clock. `busy` then stays high for exactly PROG_CYCLES cycles for a program, or ERASE_CYCLES cycles for an erase.
- R2: A read during a busy program returns bit 7 equal to the inverse of `cmd_poll_ref` as latched when that command was accepted.
- R3: A read during a busy erase returns bit 7 equal to 0.
- R4: A read while idle returns bits 7 and 6 equal to `rd_data` bits 7 and 6. After an erase this shows the erased value of 1.
- R5: Each read while busy returns bit 6 equal to a toggle state and then inverts that state. The state is 0 after reset, so successive busy reads alternate.
- R6: The toggle state does not change on idle reads, or on cycles where the strobe is held high or low. A strobe held high counts as one read.
- R7: Bits 5 to 0 of every returned byte equal `rd_data` bits 5 to 0 at the read.
- R8: A command presented while `busy` is high is ignored. The running operation's kind, its latched bit 7 and its end time are all unchanged.
- R9: Reset clears `dout` and `busy` to 0. `dout` is loaded one clock after a rising edge of `rd_strobe` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start an operation (taken only when idle) |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_poll_ref | input | 1 | Top bit of the last byte loaded |
| rd_strobe | input | 1 | Read strobe; a read happens on its rising edge |
| rd_data | input | DATA_W | Array data for the current read |
| dout | output | DATA_W | Registered byte returned to the host |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with PROG_CYCLES=6 and ERASE_CYCLES=10. These are short enough that several reads fit inside one operation and completion arrives within a few dozen cycles. Because the two lengths differ, a wrongly accepted overlapping command shows up as a shifted end time or a wrong bit 7. The short program length also allows a strobe to rise in the last busy cycle and stay high across completion, which tests both the held-strobe rule and the end of toggling.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  // Context captured when an operation starts
  typedef struct packed {
    op_kind_e kind;
    logic     ref_msb;
  } op_ctx_t;

endpackage

// File: rtl/pe_busy_timer.sv
module pe_busy_timer
  import pe_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 64,
  parameter int ERASE_CYCLES = 512
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  logic    cmd_erase,
  input  logic    cmd_poll_ref,
  output logic    busy,
  output op_ctx_t ctx
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  op_ctx_t       ctx_q;
  logic          accept;

  assign accept = cmd_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ctx_q  <= '{kind: OP_PROGRAM, ref_msb: 1'b0};
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (accept) begin
      busy_q        <= 1'b1;
      cnt_q         <= cmd_erase ? ERASE_LOAD : PROG_LOAD;
      ctx_q.kind    <= cmd_erase ? OP_ERASE : OP_PROGRAM;
      ctx_q.ref_msb <= cmd_poll_ref;
    end
  end

  assign busy = busy_q;
  assign ctx  = ctx_q;

  // R1: busy only starts after a command
  p_start_needs_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(cmd_valid));

  // R1: busy cannot end while cycles remain
  p_no_early_end_r1: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R8: command during busy leaves context untouched
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_valid) |=> $stable(ctx_q));

endmodule

// File: rtl/pe_toggle_gen.sv
module pe_toggle_gen (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  input  logic busy,
  output logic rd_rise,
  output logic tog
);

  logic prev_q;
  logic tog_q;

  assign rd_rise = rd_strobe && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= rd_strobe;
      if (rd_rise && busy) tog_q <= ~tog_q;
    end
  end

  assign tog = tog_q;

  // R5: every busy read inverts the toggle
  p_tog_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_rise) |=> (tog_q != $past(tog_q)));

  // R6: no busy read, no change
  p_tog_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && rd_rise) |=> $stable(tog_q));

endmodule

// File: rtl/pe_read_mux.sv
module pe_read_mux
  import pe_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_rise,
  input  logic              busy,
  input  op_ctx_t           ctx,
  input  logic              tog,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout
);

  localparam int POLL_B = DATA_W - 1;
  localparam int TOG_B  = DATA_W - 2;

  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    nxt = rd_data;
    if (busy) begin
      nxt[POLL_B] = (ctx.kind == OP_ERASE) ? 1'b0 : ~ctx.ref_msb;
      nxt[TOG_B]  = tog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          dout_q <= '0;
    else if (rd_rise) dout_q <= nxt;
  end

  assign dout = dout_q;

  // R7: low bits pass straight through
  p_low_pass_r7: assert property (@(posedge clk) disable iff (rst)
    rd_rise |=> (dout_q[TOG_B-1:0] == $past(rd_data[TOG_B-1:0])));

  // R3: erase polls as zero
  p_erase_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && busy && ctx.kind == OP_ERASE) |=> !dout_q[POLL_B]);

  // R9: output holds without a read
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_rise |=> $stable(dout_q));

endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
  import pe_status_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 64,
  parameter int ERASE_CYCLES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_erase,
  input  logic              cmd_poll_ref,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              busy
);

  logic    busy_w;
  logic    rise_w;
  logic    tog_w;
  op_ctx_t ctx_w;

  pe_busy_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_erase   (cmd_erase),
    .cmd_poll_ref(cmd_poll_ref),
    .busy        (busy_w),
    .ctx         (ctx_w)
  );

  pe_toggle_gen u_toggle (
    .clk      (clk),
    .rst      (rst),
    .rd_strobe(rd_strobe),
    .busy     (busy_w),
    .rd_rise  (rise_w),
    .tog      (tog_w)
  );

  pe_read_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .clk    (clk),
    .rst    (rst),
    .rd_rise(rise_w),
    .busy   (busy_w),
    .ctx    (ctx_w),
    .tog    (tog_w),
    .rd_data(rd_data),
    .dout   (dout)
  );

  assign busy = busy_w;

  initial begin
    assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
    assert (PROG_CYCLES >= 1 && ERASE_CYCLES >= 1) else $error("cycle counts must be positive");
  end

endmodule

// File: tb/sim_pe_status_reporter.sv
`timescale 1ns/1ps
module sim_pe_status_reporter;

  localparam int PC = 6;
  localparam int EC = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_erase = 1'b0, cmd_poll_ref = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [7:0] dout;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  pe_status_reporter #(.DATA_W(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
    .cmd_poll_ref(cmd_poll_ref), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .dout(dout), .busy(busy)
  );

  // Behavioural reference model
  bit         m_busy, m_tog, m_prev, m_erase, m_ref, m_live;
  int         m_rem;
  logic [7:0] m_dout;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_tog = 0; m_prev = 0; m_erase = 0; m_ref = 0;
      m_rem = 0; m_dout = 8'h00; m_live = 1;
    end else begin
      if (rd_strobe && !m_prev) begin
        m_dout = rd_data;
        if (m_busy) begin
          m_dout[7] = m_erase ? 1'b0 : !m_ref;
          m_dout[6] = m_tog;
          m_tog = !m_tog;
        end
      end
      m_prev = rd_strobe;
      if (m_busy) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_busy = 0;
      end else if (cmd_valid) begin
        m_busy = 1; m_erase = cmd_erase; m_ref = cmd_poll_ref;
        m_rem = cmd_erase ? EC : PC;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && m_live) begin
      checks++;
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R1 R8 busy model: got %0b exp %0b", busy, m_busy);
      end
      checks++;
      if (dout[5:0] !== m_dout[5:0]) begin
        errors++;
        $display("FAIL R7 R9 low bits model: got %h exp %h", dout, m_dout);
      end
      checks++;
      if (dout[7] !== m_dout[7]) begin
        errors++;
        $display("FAIL R2 R3 R4 poll bit model: got %h exp %h", dout, m_dout);
      end
      checks++;
      if (dout[6] !== m_dout[6]) begin
        errors++;
        $display("FAIL R5 R6 toggle bit model: got %h exp %h", dout, m_dout);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] d);
    rd_strobe = 1'b1; rd_data = d;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_cmd(input bit er, input bit msb);
    cmd_valid = 1'b1; cmd_erase = er; cmd_poll_ref = msb;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset dout", dout, 8'h00);
    chk("R9 reset busy", {7'd0, busy}, 8'h00);

    do_read(8'hA5);
    chk("R4 R7 idle read", dout, 8'hA5);

    // program, loaded top bit 1
    do_cmd(1'b0, 1'b1);
    chk("R1 busy after program cmd", {7'd0, busy}, 8'h01);
    do_read(8'h3F);
    chk("R2 R5 first busy read", dout, 8'h3F);
    do_read(8'hC0);
    chk("R2 R5 second busy read toggles", dout, 8'h40);
    rd_strobe = 1'b1; rd_data = 8'h15;
    repeat (3) @(negedge clk);
    chk("R6 held strobe one read", dout, 8'h15);
    chk("R1 program ended", {7'd0, busy}, 8'h00);
    rd_strobe = 1'b0;
    @(negedge clk);
    do_read(8'hC0);
    chk("R4 R6 idle read after program", dout, 8'hC0);

    // program duration
    do_cmd(1'b0, 1'b0);
    count_busy(n);
    chk("R1 program length", 8'(n), 8'(PC));

    // erase with an overlapping command
    do_cmd(1'b1, 1'b1);
    do_read(8'hFF);
    chk("R3 R5 erase read a", dout, 8'h7F);
    do_read(8'hFF);
    chk("R3 R5 erase read b", dout, 8'h3F);
    do_cmd(1'b0, 1'b0);
    do_read(8'hFF);
    chk("R8 R3 overlapping cmd ignored", dout, 8'h7F);
    count_busy(n);
    chk("R8 R1 erase end unchanged", 8'(n), 8'd3);
    do_read(8'hFF);
    chk("R4 erased byte reads ones", dout, 8'hFF);

    // program with loaded top bit 0
    do_cmd(1'b0, 1'b0);
    do_read(8'h00);
    chk("R2 inverse of zero", dout, 8'h80);
    count_busy(n);
    do_read(8'h2A);
    chk("R4 R7 idle pattern", dout, 8'h2A);

    // erase length
    do_cmd(1'b1, 1'b0);
    count_busy(n);
    chk("R1 erase length", 8'(n), 8'(EC));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule